// File: doc/BRIEF.md
# Multi-Stream Wall Clock Advance Guard

This block keeps a 64-bit wall-clock value that several audio streams share. Each stream reports two things: how far its own period has progressed in absolute time, and whether it has already gone beyond the value currently being requested. A requester pulses a strobe with a target value and a force flag.

When the request is not forced, the clock moves only if every active stream has passed the target. It then jumps to the largest of the target and the elapsed times of the active streams. A forced request writes the target as given. An active mask removes idle streams from both the agreement test and the maximum.

One cycle after each strobe the block reports whether the resulting clock equals the requested target. A mismatch means the update was delayed. The block also counts non-forced updates that leave the clock unchanged and raises a warning when this keeps happening.

Top module: `wclk_advance_guard`

## Requirements
- R1: After reset, the wall clock is 0, the result-valid flag is 0, the on-time flag is 0 and the stale warning is 0.
- R2: On a non-forced request where any active stream has its passed bit at 0, the wall clock does not change.
- R3: A stream whose active bit is 0 is ignored. Its passed bit does not block an update, and its elapsed time does not enter the maximum.
- R4: On a non-forced request where all active streams have passed, the wall clock becomes the maximum of the target and the elapsed times of the active streams, whenever that maximum exceeds the current value.
- R5: A non-forced request never moves the wall clock backwards. If the computed maximum is not above the current value, the clock holds and the event counts as stale.
- R6: A forced request loads the target directly, even when it is lower than the current value and even when streams have not passed.
- R7: Each stale event (a non-forced, all-passed request that leaves the clock unchanged) increments a stale count. A stale event that finds the count already above STALE_LIMIT (default 3) sets the stale warning. With the default, the warning is set on the fifth consecutive stale event.
- R8: Any request that changes the wall clock value clears the stale count and the stale warning. A forced request to the current value, or a rejected request, leaves both as they were.
- R9: In the cycle after a strobe, the result-valid flag is 1, and the on-time flag is 1 exactly when the new wall clock equals that strobe's target. Result-valid is 0 in the cycle after a cycle with no strobe.
- R10: Without a strobe, the wall clock holds its value whatever the stream inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqTarget | input | CLK_W | Requested wall clock value |
| reqForce | input | 1 | Load the target without the stream checks |
| streamActive | input | NUM_STREAMS | Per-stream participation mask |
| streamPassed | input | NUM_STREAMS | Per-stream flag: this stream has passed the target |
| streamElapsed | input | NUM_STREAMS*CLK_W | Packed absolute elapsed times, stream i at bits [i*CLK_W +: CLK_W] |
| wallClock | output | CLK_W | Current wall clock value |
| resultValid | output | 1 | High in the cycle after a strobe |
| resultOnTime | output | 1 | New value equals the strobe's target (0 means delayed) |
| staleWarn | output | 1 | Repeated stale update warning |

## Verification
The bench builds the block with three streams, the full 64-bit width and a stale limit of 3. Three streams are enough to mix active and idle streams, so one idle stream can carry a huge elapsed time and a low passed bit while the other two decide the maximum. The limit of 3 keeps the warning boundary (the fifth stale event in a row) within a few requests. The bench can therefore cover the run that stops one short of the warning after a clearing advance, as well as the warning itself and its removal by a forced jump backwards.

// File: rtl/wclk_guard_pkg.sv
package wclk_guard_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadMerged;   // take max(target, active elapsed)
    logic loadTarget;   // take the raw target (forced)
    logic capture;      // latch the result flags for this request
  } wclkCtrl_t;

  // Comparison results from datapath to control
  typedef struct packed {
    logic mergedAhead;    // merged maximum is above current clock
    logic targetDiffers;  // raw target differs from current clock
  } wclkStat_t;

endpackage

// File: rtl/wclk_guard_datapath.sv
module wclk_guard_datapath
  import wclk_guard_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 3,
  parameter int unsigned CLK_W       = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CLK_W-1:0]             reqTarget,
  input  logic [NUM_STREAMS-1:0]       streamActive,
  input  logic [NUM_STREAMS*CLK_W-1:0] streamElapsed,
  input  wclkCtrl_t                    ctrl,
  output wclkStat_t                    stat,
  output logic [CLK_W-1:0]             wallClock,
  output logic                         resultValid,
  output logic                         resultOnTime
);

  // Running maximum chain, seeded with the target
  logic [CLK_W-1:0] runMax [NUM_STREAMS+1];
  assign runMax[0] = reqTarget;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gMax
    logic [CLK_W-1:0] elapsedG;
    assign elapsedG = streamElapsed[g*CLK_W +: CLK_W];
    assign runMax[g+1] = (streamActive[g] && (elapsedG > runMax[g])) ? elapsedG : runMax[g];
  end

  logic [CLK_W-1:0] mergedMax;
  logic [CLK_W-1:0] clockQ;
  logic [CLK_W-1:0] clockD;

  assign mergedMax          = runMax[NUM_STREAMS];
  assign stat.mergedAhead   = mergedMax > clockQ;
  assign stat.targetDiffers = reqTarget != clockQ;

  always_comb begin
    clockD = clockQ;
    if (ctrl.loadTarget)      clockD = reqTarget;
    else if (ctrl.loadMerged) clockD = mergedMax;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clockQ       <= '0;
      resultValid  <= 1'b0;
      resultOnTime <= 1'b0;
    end else begin
      clockQ      <= clockD;
      resultValid <= ctrl.capture;
      if (ctrl.capture) resultOnTime <= (clockD == reqTarget);
    end
  end

  assign wallClock = clockQ;

endmodule

// File: rtl/wclk_guard_control.sv
module wclk_guard_control
  import wclk_guard_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 3,
  parameter int unsigned STALE_LIMIT = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqForce,
  input  logic [NUM_STREAMS-1:0] streamActive,
  input  logic [NUM_STREAMS-1:0] streamPassed,
  input  wclkStat_t              stat,
  output wclkCtrl_t              ctrl,
  output logic                   staleWarn
);

  localparam int unsigned STALE_W = $clog2(STALE_LIMIT + 2);

  logic               allPassed;
  logic               staleEvent;
  logic               changeEvent;
  logic [STALE_W-1:0] staleCnt;

  // Idle streams count as passed
  assign allPassed = &(streamPassed | ~streamActive);

  assign ctrl.capture    = reqValid;
  assign ctrl.loadTarget = reqValid && reqForce;
  assign ctrl.loadMerged = reqValid && !reqForce && allPassed && stat.mergedAhead;

  assign staleEvent  = reqValid && !reqForce && allPassed && !stat.mergedAhead;
  assign changeEvent = ctrl.loadMerged || (ctrl.loadTarget && stat.targetDiffers);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staleCnt  <= '0;
      staleWarn <= 1'b0;
    end else if (changeEvent) begin
      staleCnt  <= '0;
      staleWarn <= 1'b0;
    end else if (staleEvent) begin
      if (staleCnt > STALE_W'(STALE_LIMIT)) staleWarn <= 1'b1;
      if (staleCnt != '1) staleCnt <= staleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/wclk_advance_guard.sv
module wclk_advance_guard
  import wclk_guard_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 3,
  parameter int unsigned CLK_W       = 64,
  parameter int unsigned STALE_LIMIT = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [CLK_W-1:0]             reqTarget,
  input  logic                         reqForce,
  input  logic [NUM_STREAMS-1:0]       streamActive,
  input  logic [NUM_STREAMS-1:0]       streamPassed,
  input  logic [NUM_STREAMS*CLK_W-1:0] streamElapsed,
  output logic [CLK_W-1:0]             wallClock,
  output logic                         resultValid,
  output logic                         resultOnTime,
  output logic                         staleWarn
);

  wclkCtrl_t ctrl;
  wclkStat_t stat;

  wclk_guard_control #(
    .NUM_STREAMS(NUM_STREAMS),
    .STALE_LIMIT(STALE_LIMIT)
  ) u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqForce(reqForce),
    .streamActive(streamActive), .streamPassed(streamPassed),
    .stat(stat), .ctrl(ctrl), .staleWarn(staleWarn)
  );

  wclk_guard_datapath #(
    .NUM_STREAMS(NUM_STREAMS),
    .CLK_W(CLK_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .reqTarget(reqTarget),
    .streamActive(streamActive), .streamElapsed(streamElapsed),
    .ctrl(ctrl), .stat(stat), .wallClock(wallClock),
    .resultValid(resultValid), .resultOnTime(resultOnTime)
  );

endmodule

// File: rtl/wclk_advance_guard_checker.sv
module wclk_advance_guard_checker #(
  parameter int unsigned NUM_STREAMS = 3,
  parameter int unsigned CLK_W       = 64
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic [CLK_W-1:0]       reqTarget,
  input logic                   reqForce,
  input logic [NUM_STREAMS-1:0] streamActive,
  input logic [NUM_STREAMS-1:0] streamPassed,
  input logic [CLK_W-1:0]       wallClock,
  input logic                   resultValid,
  input logic                   resultOnTime,
  input logic                   staleWarn
);

  logic blocked;
  assign blocked = |(streamActive & ~streamPassed);

  // R2
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqForce && blocked) |=> $stable(wallClock));

  // R5
  no_backwards_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqForce) |=> (wallClock >= $past(wallClock)));

  // R6
  force_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqForce) |=> (wallClock == $past(reqTarget)));

  // R9
  result_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resultValid);

  // R9
  result_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resultValid);

  // R9
  on_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultOnTime == (wallClock == $past(reqTarget))));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(wallClock));

  // R8
  change_clears_warn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wallClock != $past(wallClock)) |-> !staleWarn);

endmodule

bind wclk_advance_guard wclk_advance_guard_checker #(
  .NUM_STREAMS(NUM_STREAMS),
  .CLK_W(CLK_W)
) u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
  .reqForce(reqForce), .streamActive(streamActive), .streamPassed(streamPassed),
  .wallClock(wallClock), .resultValid(resultValid), .resultOnTime(resultOnTime),
  .staleWarn(staleWarn)
);

// File: tb/wclk_advance_guard_bench.sv
module wclk_advance_guard_bench;

  localparam int unsigned NS = 3;
  localparam int unsigned W  = 64;
  localparam int unsigned CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [W-1:0]    reqTarget = '0;
  logic            reqForce = 1'b0;
  logic [NS-1:0]   streamActive = '0;
  logic [NS-1:0]   streamPassed = '0;
  logic [NS*W-1:0] streamElapsed = '0;
  logic [W-1:0]    wallClock;
  logic            resultValid, resultOnTime, staleWarn;

  wclk_advance_guard #(.NUM_STREAMS(NS), .CLK_W(W), .STALE_LIMIT(3)) u_wclk_advance_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
    .reqForce(reqForce), .streamActive(streamActive), .streamPassed(streamPassed),
    .streamElapsed(streamElapsed), .wallClock(wallClock), .resultValid(resultValid),
    .resultOnTime(resultOnTime), .staleWarn(staleWarn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [W-1:0] mClock = '0;
  int           mStale = 0;
  bit           mWarn = 0;
  bit           mValid = 0;
  bit           mOnTime = 0;
  logic [W-1:0] el [NS];

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "wallClock", wallClock, mClock);
    chk(tag, "resultValid", W'(resultValid), W'(mValid));
    if (mValid) chk(tag, "resultOnTime", W'(resultOnTime), W'(mOnTime));
    chk(tag, "staleWarn", W'(staleWarn), W'(mWarn));
  endtask

  // One clock: drive at negedge, advance model, compare at next negedge
  task automatic step(bit v, logic [W-1:0] tgt, bit frc, string tag);
    bit allOk;
    logic [W-1:0] mx;
    reqValid  = v;
    reqTarget = tgt;
    reqForce  = frc;
    for (int i = 0; i < NS; i++) streamElapsed[i*W +: W] = el[i];
    allOk = 1;
    mx = tgt;
    for (int i = 0; i < NS; i++) begin
      if (streamActive[i]) begin
        if (!streamPassed[i]) allOk = 0;
        if (el[i] > mx) mx = el[i];
      end
    end
    if (v) begin
      if (frc) begin
        if (tgt != mClock) begin mClock = tgt; mStale = 0; mWarn = 0; end
      end else if (allOk) begin
        if (mx > mClock) begin mClock = mx; mStale = 0; mWarn = 0; end
        else begin
          if (mStale > 3) mWarn = 1;
          mStale++;
        end
      end
      mOnTime = (mClock == tgt);
    end
    mValid = v;
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) el[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    streamActive = 3'b111;
    streamPassed = 3'b111;
    el[0] = 100; el[1] = 200; el[2] = 150;
    // R4 merged maximum is a stream elapsed, delayed result (R9)
    step(1, 50, 0, "R4");
    step(0, 0, 0, "R9");
    // R4 target is the maximum, on time
    step(1, 300, 0, "R4");
    // R2 one active stream not passed
    streamPassed = 3'b101;
    step(1, 400, 0, "R2");
    // R10 idle with changing inputs
    el[0] = 9000;
    step(0, 777, 0, "R10");
    step(0, 888, 1, "R10");
    el[0] = 100;
    // R3 idle stream with low passed bit and huge elapsed is ignored
    streamActive = 3'b101;
    el[1] = 64'd1000000;
    step(1, 400, 0, "R3");
    // R5 target below current: hold, stale events
    streamPassed = 3'b111;
    step(1, 350, 0, "R5");
    step(1, 120, 0, "R5");
    // R8 advancing clears the count
    step(1, 500, 0, "R8");
    // R7 four stale events in a row: no warning
    for (int k = 0; k < 4; k++) step(1, 500, 0, "R7");
    // R7 fifth stale event sets the warning
    step(1, 490, 0, "R7");
    step(1, 480, 0, "R7");
    // R8 forced to the same value leaves the warning
    step(1, 500, 1, "R8");
    // R2 rejected request keeps the warning
    streamPassed = 3'b100;
    step(1, 900, 0, "R2");
    // R6 forced backwards with streams not passed, clears warning (R8)
    step(1, 10, 1, "R6");
    // R6 forced forward
    step(1, 64'hFFFF_FFFF_0000_0001, 1, "R6");
    // R4 all streams idle: target alone
    streamActive = 3'b000;
    step(1, 64'hFFFF_FFFF_FFFF_FFF0, 0, "R4");
    // R5 merged below current after large value
    streamActive = 3'b111;
    streamPassed = 3'b111;
    step(1, 5, 0, "R5");
    // R1 reset mid-run
    rstN = 1'b0;
    mClock = '0; mStale = 0; mWarn = 0; mValid = 0; mOnTime = 0;
    reqValid = 1'b0;
    @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    step(0, 0, 0, "R10");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule